// File: doc/BRIEF.md
# Serial JTAG Pin Driver

This block turns a stream of ASCII bytes into levels on the three JTAG drive pins of a target and answers readback requests with the level of the target's data-out pin. It sits behind a byte transport, such as a UART or a socket bridge, that carries commands from a host debugger. The block does not track the TAP state machine. The host decides every edge of the test clock.

Each command is one byte. A digit from '0' to '7' is a pin-set command. Its numeric value gives the new levels of TDI, TMS and TCK in one step. The capital letter 'R' is a readback command. It samples TDO and queues a single reply byte, either '0' or '1'. A host normally sends one pin-set byte and then one 'R' for every pin change, and waits for the reply before it sends more. Any other byte is taken from the stream and dropped.

Both byte streams use valid/ready handshakes. While a reply waits at the output, the input stream is stalled. A second readback therefore cannot overwrite a reply that has not been collected.

Top module: `jtag_bitbang_bridge`

## Requirements
- R1: After a synchronous active-low reset, `tck`, `tms` and `tdi` are 0, `out_valid` is 0 and `in_ready` is 1.
- R2: When a byte from 0x30 to 0x37 is accepted, the pins take the value (byte − 0x30) on the next clock edge. Bit 0 of that value goes to `tdi`, bit 1 goes to `tms` and bit 2 goes to `tck`.
- R3: An accepted 0x52 ('R') leaves `tck`, `tms` and `tdi` unchanged.
- R4: When 0x52 is accepted, `tdo` is sampled in that cycle. From the next cycle, `out_valid` is 1 and `out_data` is 0x30 plus the sampled bit, so it reads 0x30 or 0x31.
- R5: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` does not change, even if `tdo` changes.
- R6: While a reply is pending, `in_ready` is 0. A byte offered during that time is not taken and changes nothing.
- R7: Any byte other than 0x30–0x37 and 0x52 is accepted (`in_ready` is 1). It changes no pin and produces no reply.
- R8: After the cycle in which `out_valid` and `out_ready` are both 1, `out_valid` is 0 and `in_ready` is 1.
- R9: The pins keep their levels in any cycle in which no pin-set byte is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_data | input | 8 | Command byte |
| in_valid | input | 1 | Command byte present |
| in_ready | output | 1 | Block can take a command byte |
| out_data | output | 8 | Reply byte ('0' or '1') |
| out_valid | output | 1 | Reply byte present |
| out_ready | input | 1 | Sink takes the reply byte |
| tck | output | 1 | Test clock level to target |
| tms | output | 1 | Test mode select level to target |
| tdi | output | 1 | Test data level to target |
| tdo | input | 1 | Test data from target |

## Verification
The bench checks the edges of the accepted byte range:
- '/' (just below '0'), '8' and '9' (just above '7'), and a lowercase 'r'. A decoder that got the range or the letter wrong would move pins or emit a reply for these bytes.
- A reply held under backpressure while `tdo` toggles. A design that samples late, or reloads the reply, would return the newer level.
- A pin-set byte offered during a pending reply. A design that ignores `in_ready` would move the pins early.
- Reset applied with a reply pending and the pins high. A design with an incomplete reset would leave stale output.

// File: rtl/jbb_pkg.sv
// Package: shared types for the serial JTAG pin driver.
// Assumes: nothing beyond standard SystemVerilog.
package jbb_pkg;

    // Kind of command a received byte represents
    typedef enum logic [1:0] {
        CMD_DROP = 2'd0,
        CMD_PINS = 2'd1,
        CMD_READ = 2'd2
    } cmd_kind_t;

endpackage

// File: rtl/jbb_cmd_decode.sv
// Module: jbb_cmd_decode
// Classifies one byte as a pin-set command, a readback command, or a byte
// to drop. For a pin-set command it also gives the pin value.
// Assumes: pin-set codes are a contiguous range starting at ZERO_CHAR.
module jbb_cmd_decode
    import jbb_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int PIN_COUNT = 3,
    parameter logic [DATA_W-1:0] ZERO_CHAR = 8'h30,
    parameter logic [DATA_W-1:0] READ_CHAR = 8'h52
) (
    input  logic [DATA_W-1:0]    byte_in,
    output cmd_kind_t            kind,
    output logic [PIN_COUNT-1:0] pin_val
);
    localparam int PIN_CODES = 1 << PIN_COUNT;

    logic [DATA_W-1:0] offset;

    // Distance of the byte above the first pin-set code
    assign offset  = byte_in - ZERO_CHAR;
    assign pin_val = offset[PIN_COUNT-1:0];

    // Pick the command kind from the byte value
    always_comb begin
        if (byte_in >= ZERO_CHAR && offset < DATA_W'(PIN_CODES)) begin
            kind = CMD_PINS;
        end else if (byte_in == READ_CHAR) begin
            kind = CMD_READ;
        end else begin
            kind = CMD_DROP;
        end
    end

endmodule

// File: rtl/jbb_pin_bank.sv
// Module: jbb_pin_bank
// A bank of registered pin levels. The whole bank loads at once on
// load_en and holds otherwise.
// Assumes: synchronous active-low reset; all pins reset low.
module jbb_pin_bank #(
    parameter int PIN_COUNT = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load_en,
    input  logic [PIN_COUNT-1:0] load_val,
    output logic [PIN_COUNT-1:0] pins
);
    for (genvar i = 0; i < PIN_COUNT; i++) begin : g_pin
        logic level_q;

        // Hold or load one pin level
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                level_q <= 1'b0;
            end else if (load_en) begin
                level_q <= load_val[i];
            end
        end

        assign pins[i] = level_q;
    end

    // R9
    pins_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |=> $stable(pins));

endmodule

// File: rtl/jbb_reply_slot.sv
// Module: jbb_reply_slot
// A one-entry holding register for the readback reply. It captures the
// data-out bit when a readback is accepted and presents ZERO_CHAR plus
// that bit until the sink takes it.
// Assumes: capture is never asserted while a reply is pending.
module jbb_reply_slot #(
    parameter int DATA_W = 8,
    parameter logic [DATA_W-1:0] ZERO_CHAR = 8'h30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic              tdo_bit,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);
    // Track whether a reply is pending
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
        end else if (capture) begin
            out_valid <= 1'b1;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    // Latch the reply character at capture time
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_data <= ZERO_CHAR;
        end else if (capture) begin
            out_data <= ZERO_CHAR + DATA_W'(tdo_bit);
        end
    end

    // R4
    reply_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> out_valid && out_data == ZERO_CHAR + DATA_W'($past(tdo_bit)));

    // R4
    reply_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_data == ZERO_CHAR || out_data == ZERO_CHAR + 1'b1));

    // R5
    reply_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data));

    // R6
    no_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !capture);

endmodule

// File: rtl/jtag_bitbang_bridge.sv
// Module: jtag_bitbang_bridge (top)
// Takes single-byte commands from a valid/ready stream. It drives the TCK,
// TMS and TDI levels, and answers readback requests with one byte on a
// valid/ready output stream.
// Assumes: synchronous active-low reset; TDO is already synchronous to clk.
module jtag_bitbang_bridge
    import jbb_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter logic [DATA_W-1:0] ZERO_CHAR = 8'h30,
    parameter logic [DATA_W-1:0] READ_CHAR = 8'h52
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              tck,
    output logic              tms,
    output logic              tdi,
    input  logic              tdo
);
    localparam int PIN_COUNT = 3;
    localparam int TDI_BIT   = 0;
    localparam int TMS_BIT   = 1;
    localparam int TCK_BIT   = 2;

    cmd_kind_t            kind;
    logic [PIN_COUNT-1:0] pin_val;
    logic [PIN_COUNT-1:0] pins;
    logic                 accept;
    logic                 load_pins;
    logic                 capture;

    // Stall the input while a reply waits; decode accepted bytes
    assign in_ready  = !out_valid;
    assign accept    = in_valid && in_ready;
    assign load_pins = accept && (kind == CMD_PINS);
    assign capture   = accept && (kind == CMD_READ);

    jbb_cmd_decode #(
        .DATA_W    (DATA_W),
        .PIN_COUNT (PIN_COUNT),
        .ZERO_CHAR (ZERO_CHAR),
        .READ_CHAR (READ_CHAR)
    ) u_decode (
        .byte_in (in_data),
        .kind    (kind),
        .pin_val (pin_val)
    );

    jbb_pin_bank #(
        .PIN_COUNT (PIN_COUNT)
    ) u_pins (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (load_pins),
        .load_val (pin_val),
        .pins     (pins)
    );

    jbb_reply_slot #(
        .DATA_W    (DATA_W),
        .ZERO_CHAR (ZERO_CHAR)
    ) u_reply (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (capture),
        .tdo_bit   (tdo),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    assign tdi = pins[TDI_BIT];
    assign tms = pins[TMS_BIT];
    assign tck = pins[TCK_BIT];

    // R2
    pin_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && in_data >= ZERO_CHAR && in_data < ZERO_CHAR + 8'd8
        |=> {tck, tms, tdi} == $past(in_data[2:0] - ZERO_CHAR[2:0]));

    // R3
    read_keeps_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && in_data == READ_CHAR |=> $stable({tck, tms, tdi}));

    // R7
    drop_no_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && in_data != READ_CHAR
        && (in_data < ZERO_CHAR || in_data >= ZERO_CHAR + 8'd8)
        |=> $stable({tck, tms, tdi}) && !out_valid);

    // R8
    drain_reopen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready |=> in_ready && !out_valid);

endmodule

// File: tb/tb_jtag_bitbang_bridge.sv
module tb_jtag_bitbang_bridge;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 15;

    // {char[20:13], tdo[12], pins tck/tms/tdi[11:9], reply[8], byte[7:0]}
    localparam logic [20:0] VEC [NVEC] = '{
        {8'h35, 1'b0, 3'b101, 1'b0, 8'h00},
        {8'h52, 1'b1, 3'b101, 1'b1, 8'h31},
        {8'h32, 1'b0, 3'b010, 1'b0, 8'h00},
        {8'h52, 1'b0, 3'b010, 1'b1, 8'h30},
        {8'h78, 1'b1, 3'b010, 1'b0, 8'h00},
        {8'h37, 1'b0, 3'b111, 1'b0, 8'h00},
        {8'h52, 1'b1, 3'b111, 1'b1, 8'h31},
        {8'h30, 1'b1, 3'b000, 1'b0, 8'h00},
        {8'h39, 1'b0, 3'b000, 1'b0, 8'h00},
        {8'h52, 1'b0, 3'b000, 1'b1, 8'h30},
        {8'h34, 1'b0, 3'b100, 1'b0, 8'h00},
        {8'h33, 1'b1, 3'b011, 1'b0, 8'h00},
        {8'h52, 1'b1, 3'b011, 1'b1, 8'h31},
        {8'h36, 1'b0, 3'b110, 1'b0, 8'h00},
        {8'h31, 1'b0, 3'b001, 1'b0, 8'h00}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] out_data;
    logic       out_valid;
    logic       out_ready = 1'b0;
    logic       tck, tms, tdi;
    logic       tdo = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    jtag_bitbang_bridge dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_data   (in_data),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .out_data  (out_data),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .tck       (tck),
        .tms       (tms),
        .tdi       (tdi),
        .tdo       (tdo)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Offer one byte for one cycle; returns at the following negedge
    task automatic push(input logic [7:0] c, input logic t);
        @(negedge clk);
        in_data  = c;
        in_valid = 1'b1;
        tdo      = t;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic drain();
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 pins", {29'd0, tck, tms, tdi}, 32'd0);
        chk("R1 out_valid", out_valid, 1'b0);
        chk("R1 in_ready", in_ready, 1'b1);
        rst_n = 1'b1;

        // Table walk: R2 pin set, R3/R4 readback, R7 dropped bytes
        for (int i = 0; i < NVEC; i++) begin
            chk("R7 in_ready before byte", in_ready, 1'b1);
            push(VEC[i][20:13], VEC[i][12]);
            chk("R2 R3 R9 pins", {29'd0, tck, tms, tdi}, {29'd0, VEC[i][11:9]});
            chk("R4 R7 out_valid", out_valid, VEC[i][8]);
            if (VEC[i][8]) begin
                chk("R4 reply byte", out_data, VEC[i][7:0]);
                drain();
                chk("R8 out_valid cleared", out_valid, 1'b0);
                chk("R8 in_ready back", in_ready, 1'b1);
            end
        end

        // R7 bytes at the range edges: '/', '8', 'r'
        push(8'h2F, 1'b1);
        push(8'h38, 1'b1);
        push(8'h72, 1'b1);
        chk("R7 edge bytes pins", {29'd0, tck, tms, tdi}, 32'd1);
        chk("R7 edge bytes no reply", out_valid, 1'b0);

        // R5 / R6 backpressure: reply held, input stalled
        push(8'h52, 1'b1);
        in_data  = 8'h37;
        in_valid = 1'b1;
        tdo      = 1'b0;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk("R5 held valid", out_valid, 1'b1);
            chk("R5 held data", out_data, 8'h31);
            chk("R6 in_ready low", in_ready, 1'b0);
            chk("R6 pins unchanged", {29'd0, tck, tms, tdi}, 32'd1);
        end
        in_valid = 1'b0;
        drain();
        chk("R8 after backpressure", in_ready, 1'b1);
        chk("R6 pins after stall", {29'd0, tck, tms, tdi}, 32'd1);

        // R1 reset with pins high and a reply pending
        push(8'h37, 1'b0);
        push(8'h52, 1'b1);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 pins after reset", {29'd0, tck, tms, tdi}, 32'd0);
        chk("R1 reply cleared", out_valid, 1'b0);
        chk("R1 in_ready after reset", in_ready, 1'b1);
        rst_n = 1'b1;

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule